// File: doc/BRIEF.md
# Emulation Control Store Selector

This block is the microcode store of a small microsequencer. It contains a fixed 512 x 32 ROM image and a RAM of the same or half the size that the host loads. While the emulation bit is clear, the sequencer fetches from the ROM and the host may read and write the RAM through a plain single-cycle bus port. When the emulation bit is set, the RAM takes the place of the ROM for fetches that fall inside it, and the host loses all access to it. When the RAM is half size it shadows only the lower 256 long words. Fetches above that range still come from the ROM.

The block also forms entry-point addresses. Sixteen functions each own sixteen 16-bit entry words, packed two to a long word, in a 128-long-word segment ordered by function number. A fetch can be issued either at a plain long-word address or at the entry point picked by a function number and an entry index. In the second case the block also hands back the 16-bit half of the fetched word that the index selects. Any part of the segment whose function numbers are unused is ordinary store space, so plain fetches may read it as code.

Top module: `ctrl_store_sel`

## Requirements
- R1: After reset, fetch_data, ep_word and host_rdata are all zero and host_err is low.
- R2: With emu_mode low, a fetch (fetch_en high at a clock edge) puts on fetch_data, right after that edge, the ROM word at the fetch address. The ROM word at address a is (a * 0x9E3779B1) ^ 0xA5C30F1E, taken modulo 2^32.
- R3: With emu_mode high and a full-size RAM (2048 bytes), every fetch returns the RAM long word at the fetch address one cycle later.
- R4: With a 1024-byte RAM and emu_mode high, fetches to addresses 0..255 return RAM word address[7:0], and fetches to addresses 256..511 return the ROM word.
- R5: ep_addr equals 384 + ep_func*8 + (ep_idx >> 1), combinationally. A fetch with fetch_ep high uses ep_addr in place of fetch_addr.
- R6: After a fetch with fetch_ep high, ep_word is fetch_data[31:16] when ep_idx was even and fetch_data[15:0] when it was odd. After a fetch with fetch_ep low, ep_word is fetch_data[31:16].
- R7: With emu_mode low, a host write (host_sel and host_we high) updates each byte lane i (bits 8i+7..8i) for which host_be[i] is set, and leaves the other lanes unchanged. A host read (host_sel high, host_we low) shows the RAM word on host_rdata in the next cycle. In any cycle that does not follow an accepted read, host_rdata is zero.
- R8: With emu_mode high, a host access has no effect. A write leaves the RAM unchanged, as a later read with emu_mode low shows. A read returns zero. host_err is high for exactly the one cycle after each such access and is low after every other cycle.
- R9: The store that serves a fetch is chosen by the value of emu_mode at the fetch's own edge. With emu_mode changing every cycle, each fetch of a back-to-back series comes from the store chosen by its own cycle.
- R10: While fetch_en is low, fetch_data and ep_word keep their values, even while host reads change the RAM read path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| emu_mode | input | 1 | Emulation mode: RAM serves fetches, host locked out |
| fetch_en | input | 1 | Fetch request this cycle |
| fetch_ep | input | 1 | Fetch at the entry point instead of fetch_addr |
| fetch_addr | input | 9 | Long-word fetch address |
| ep_func | input | 4 | Function number for the entry point |
| ep_idx | input | 4 | Entry index within the function |
| ep_addr | output | 9 | Computed entry-point long-word address |
| fetch_data | output | 32 | Fetched long word, one cycle after the request |
| ep_word | output | 16 | Selected 16-bit entry word of the last fetch |
| host_sel | input | 1 | Host access this cycle |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | 9 | Host long-word address in the RAM (8 bits when RAM is 1024 bytes) |
| host_be | input | 4 | Host byte-lane enables |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle after the read |
| host_err | output | 1 | One-cycle pulse after a host access refused in emulation |

## Verification
The hardest situation to reach from the ports is a mode switch that meets traffic in flight. One case is a fetch served from the RAM followed by emulation turning off and a host read moving the shared RAM read path while fetch_en is low. The other is emu_mode toggling on every cycle of a back-to-back fetch series. Directed sequences set up both cases after the RAM has been filled with random data. Seeded random cycles then mix mode, fetch kind and host traffic, and two instances (full-size and half-size RAM) run in lockstep against bench models.

// File: rtl/ucs_pkg.sv
package ucs_pkg;

   localparam int unsigned LANE_W = 8;

   typedef enum logic {
      SRC_ROM = 1'b0,
      SRC_RAM = 1'b1
   } store_src_e;

   // Fixed microcode image: a multiplicative hash of the long-word address.
   function automatic logic [31:0] rom_image(input logic [31:0] lw_addr);
      logic [31:0] prod;
      prod = lw_addr * 32'h9E37_79B1;
      return prod ^ 32'hA5C3_0F1E;
   endfunction

endpackage

// File: rtl/ucs_rom.sv
module ucs_rom #(
   parameter int unsigned ADDR_W = 9,
   parameter int unsigned DATA_W = 32
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] rdata
);
   import ucs_pkg::*;

   if (DATA_W > 32) begin : g_bad_width
      $error("ucs_rom: DATA_W above 32 is not supported by the image");
   end

   logic [31:0] word;

   always_comb begin
      word  = rom_image(32'(addr));
      rdata = word[DATA_W-1:0];
   end

endmodule

// File: rtl/ucs_ram.sv
module ucs_ram #(
   parameter int unsigned ADDR_W = 9,
   parameter int unsigned DATA_W = 32,
   localparam int unsigned LANES = DATA_W / 8,
   localparam int unsigned DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic [LANES-1:0]  be,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   if (DATA_W % 8 != 0) begin : g_bad_lanes
      $error("ucs_ram: DATA_W must be a whole number of bytes");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         for (int ln = 0; ln < int'(LANES); ln++) begin
            if (be[ln]) begin
               mem[addr][ln*8 +: 8] <= wdata[ln*8 +: 8];
            end
         end
      end
   end

   assign rdata = mem[addr];

endmodule

// File: rtl/ucs_ep_gen.sv
module ucs_ep_gen #(
   parameter int unsigned ADDR_W  = 9,
   parameter int unsigned FUNC_W  = 4,
   parameter int unsigned IDX_W   = 4,
   parameter int unsigned EP_BASE = 384,
   localparam int unsigned OFF_W  = FUNC_W + IDX_W - 1,
   localparam int unsigned SEG_LW = 1 << OFF_W
) (
   input  logic [FUNC_W-1:0] func,
   input  logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] ep_addr,
   output logic              lo_half
);

   if (EP_BASE + SEG_LW > (1 << ADDR_W)) begin : g_bad_seg
      $error("ucs_ep_gen: entry segment does not fit the store");
   end
   if (EP_BASE % (1 << (IDX_W - 1)) != 0) begin : g_bad_align
      $error("ucs_ep_gen: EP_BASE must align to one function's entries");
   end

   logic [OFF_W-1:0] offset;

   always_comb begin
      offset  = {func, idx[IDX_W-1:1]};
      ep_addr = ADDR_W'(EP_BASE) + ADDR_W'(offset);
      lo_half = idx[0];
   end

endmodule

// File: rtl/ucs_host_gate.sv
module ucs_host_gate #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              emu_mode,
   input  logic              host_sel,
   input  logic              host_we,
   input  logic [DATA_W-1:0] ram_rd,
   output logic              ram_we,
   output logic [DATA_W-1:0] host_rdata,
   output logic              host_err
);

   logic rd_ok;
   logic blocked;

   always_comb begin
      blocked = host_sel & emu_mode;
      ram_we  = host_sel & host_we & ~emu_mode;
      rd_ok   = host_sel & ~host_we & ~emu_mode;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         host_rdata <= '0;
         host_err   <= 1'b0;
      end else begin
         host_rdata <= rd_ok ? ram_rd : '0;
         host_err   <= blocked;
      end
   end

endmodule

// File: rtl/ctrl_store_sel.sv
module ctrl_store_sel #(
   parameter int unsigned ADDR_W    = 9,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned FUNC_W    = 4,
   parameter int unsigned IDX_W     = 4,
   parameter int unsigned EP_BASE   = 384,
   parameter int unsigned RAM_BYTES = 2048,
   localparam int unsigned RAM_AW   = $clog2(RAM_BYTES / (DATA_W / 8)),
   localparam int unsigned LANES    = DATA_W / 8,
   localparam int unsigned HALF_W   = DATA_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              emu_mode,
   input  logic              fetch_en,
   input  logic              fetch_ep,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic [FUNC_W-1:0] ep_func,
   input  logic [IDX_W-1:0]  ep_idx,
   output logic [ADDR_W-1:0] ep_addr,
   output logic [DATA_W-1:0] fetch_data,
   output logic [HALF_W-1:0] ep_word,
   input  logic              host_sel,
   input  logic              host_we,
   input  logic [RAM_AW-1:0] host_addr,
   input  logic [LANES-1:0]  host_be,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              host_err
);
   import ucs_pkg::*;

   if (!(RAM_BYTES == 1024 || RAM_BYTES == 2048)) begin : g_bad_ram
      $error("ctrl_store_sel: RAM_BYTES must be 1024 or 2048");
   end
   if (RAM_AW > ADDR_W) begin : g_bad_span
      $error("ctrl_store_sel: RAM larger than the store address space");
   end

   logic [ADDR_W-1:0] eff_addr;
   logic              ep_lo;
   logic              in_ram;
   logic [RAM_AW-1:0] ram_addr;
   logic [DATA_W-1:0] ram_rd;
   logic [DATA_W-1:0] rom_rd;
   logic              ram_we;
   store_src_e        src_d;
   logic              lo_q;

   ucs_ep_gen #(
      .ADDR_W (ADDR_W),
      .FUNC_W (FUNC_W),
      .IDX_W  (IDX_W),
      .EP_BASE(EP_BASE)
   ) ep_gen_i (
      .func   (ep_func),
      .idx    (ep_idx),
      .ep_addr(ep_addr),
      .lo_half(ep_lo)
   );

   assign eff_addr = fetch_ep ? ep_addr : fetch_addr;

   // RAM coverage of the fetch space depends on its size.
   if (RAM_AW >= ADDR_W) begin : g_full_cover
      assign in_ram = 1'b1;
   end else begin : g_low_cover
      assign in_ram = ~|eff_addr[ADDR_W-1:RAM_AW];
   end

   // Single RAM port: the sequencer owns it in emulation, the host otherwise.
   assign ram_addr = emu_mode ? eff_addr[RAM_AW-1:0] : host_addr;

   ucs_rom #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
   ) rom_i (
      .addr (eff_addr),
      .rdata(rom_rd)
   );

   ucs_ram #(
      .ADDR_W(RAM_AW),
      .DATA_W(DATA_W)
   ) ram_i (
      .clk  (clk),
      .addr (ram_addr),
      .we   (ram_we),
      .be   (host_be),
      .wdata(host_wdata),
      .rdata(ram_rd)
   );

   ucs_host_gate #(
      .DATA_W(DATA_W)
   ) gate_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .emu_mode  (emu_mode),
      .host_sel  (host_sel),
      .host_we   (host_we),
      .ram_rd    (ram_rd),
      .ram_we    (ram_we),
      .host_rdata(host_rdata),
      .host_err  (host_err)
   );

   assign src_d = (emu_mode && in_ram) ? SRC_RAM : SRC_ROM;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fetch_data <= '0;
         lo_q       <= 1'b0;
      end else if (fetch_en) begin
         fetch_data <= (src_d == SRC_RAM) ? ram_rd : rom_rd;
         lo_q       <= fetch_ep & ep_lo;
      end
   end

   assign ep_word = lo_q ? fetch_data[HALF_W-1:0] : fetch_data[DATA_W-1:HALF_W];

endmodule

// File: rtl/ctrl_store_sel_chk.sv
module ctrl_store_sel_chk #(
   parameter int unsigned ADDR_W  = 9,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned FUNC_W  = 4,
   parameter int unsigned IDX_W   = 4,
   parameter int unsigned EP_BASE = 384
) (
   input logic              clk,
   input logic              rst_n,
   input logic              emu_mode,
   input logic              fetch_en,
   input logic [IDX_W-1:0]  ep_idx,
   input logic [ADDR_W-1:0] ep_addr,
   input logic [DATA_W-1:0] fetch_data,
   input logic [DATA_W/2-1:0] ep_word,
   input logic              host_sel,
   input logic [DATA_W-1:0] host_rdata,
   input logic              host_err,
   input logic              ram_we
);

   p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (host_sel && emu_mode) |=> host_err);

   p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_sel && emu_mode) |=> !host_err);

   p_err_zero_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      host_err |-> (host_rdata == '0));

   p_no_emu_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(ram_we && emu_mode));

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_en |=> ($stable(fetch_data) && $stable(ep_word)));

   p_ep_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(ep_addr) >= EP_BASE) &&
      (ep_addr[IDX_W-2:0] == ep_idx[IDX_W-1:1]));

endmodule

bind ctrl_store_sel ctrl_store_sel_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .FUNC_W (FUNC_W),
   .IDX_W  (IDX_W),
   .EP_BASE(EP_BASE)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .emu_mode  (emu_mode),
   .fetch_en  (fetch_en),
   .ep_idx    (ep_idx),
   .ep_addr   (ep_addr),
   .fetch_data(fetch_data),
   .ep_word   (ep_word),
   .host_sel  (host_sel),
   .host_rdata(host_rdata),
   .host_err  (host_err),
   .ram_we    (ram_we)
);

// File: tb/ctrl_store_sel_tb_top.sv
`timescale 1ns/100ps
module ctrl_store_sel_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        emu_mode = 1'b0;
   logic        fetch_en = 1'b0;
   logic        fetch_ep = 1'b0;
   logic [8:0]  fetch_addr = '0;
   logic [3:0]  ep_func = '0;
   logic [3:0]  ep_idx = '0;
   logic        host_sel = 1'b0;
   logic        host_we = 1'b0;
   logic [8:0]  host_addr = '0;
   logic [3:0]  host_be = '0;
   logic [31:0] host_wdata = '0;

   logic [8:0]  ep_addr_f,  ep_addr_h;
   logic [31:0] fdata_f,    fdata_h;
   logic [15:0] epw_f,      epw_h;
   logic [31:0] hrd_f,      hrd_h;
   logic        herr_f,     herr_h;

   int n_checks = 0;
   int n_fail   = 0;
   string force_tag = "";

   always #2.5 clk = ~clk;

   ctrl_store_sel #(.RAM_BYTES(2048)) dut_i (
      .clk(clk), .rst_n(rst_n), .emu_mode(emu_mode),
      .fetch_en(fetch_en), .fetch_ep(fetch_ep), .fetch_addr(fetch_addr),
      .ep_func(ep_func), .ep_idx(ep_idx), .ep_addr(ep_addr_f),
      .fetch_data(fdata_f), .ep_word(epw_f),
      .host_sel(host_sel), .host_we(host_we), .host_addr(host_addr),
      .host_be(host_be), .host_wdata(host_wdata),
      .host_rdata(hrd_f), .host_err(herr_f)
   );

   ctrl_store_sel #(.RAM_BYTES(1024)) dut_half_i (
      .clk(clk), .rst_n(rst_n), .emu_mode(emu_mode),
      .fetch_en(fetch_en), .fetch_ep(fetch_ep), .fetch_addr(fetch_addr),
      .ep_func(ep_func), .ep_idx(ep_idx), .ep_addr(ep_addr_h),
      .fetch_data(fdata_h), .ep_word(epw_h),
      .host_sel(host_sel), .host_we(host_we), .host_addr(host_addr[7:0]),
      .host_be(host_be), .host_wdata(host_wdata),
      .host_rdata(hrd_h), .host_err(herr_h)
   );

   // Bench models
   logic [31:0] m_full [512];
   logic [31:0] m_half [256];
   logic [31:0] e_fd_f = '0, e_fd_h = '0, e_hr_f = '0, e_hr_h = '0;
   logic        e_lo = 1'b0, e_err = 1'b0;

   function automatic logic [31:0] rom_ref(input int unsigned a);
      logic [31:0] p;
      p = 32'(a) * 32'h9E3779B1;
      return p ^ 32'hA5C30F1E;
   endfunction

   function automatic logic [8:0] ep_ref(input logic [3:0] f, input logic [3:0] i);
      return 9'(384 + int'(f) * 8 + int'(i) / 2);
   endfunction

   function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                         input logic [3:0] be);
      logic [31:0] r;
      r = old;
      for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
      return r;
   endfunction

   function automatic logic [15:0] half_sel(input logic [31:0] d, input logic lo);
      return lo ? d[15:0] : d[31:16];
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // One cycle: drive, update models, clock, compare.
   task automatic step(input logic em, input logic fe, input logic fp, input logic [8:0] fa,
                       input logic [3:0] fn, input logic [3:0] ix,
                       input logic hs, input logic hw, input logic [8:0] ha,
                       input logic [3:0] be, input logic [31:0] wd);
      logic [8:0] ea;
      string ft, fth;
      emu_mode = em; fetch_en = fe; fetch_ep = fp; fetch_addr = fa;
      ep_func = fn; ep_idx = ix; host_sel = hs; host_we = hw;
      host_addr = ha; host_be = be; host_wdata = wd;
      ea = fp ? ep_ref(fn, ix) : fa;
      ft  = !fe ? "R10" : (fp ? "R5" : (em ? "R3" : "R2"));
      fth = !fe ? "R10" : "R4";
      if (force_tag != "") begin ft = force_tag; fth = force_tag; end
      if (fe) begin
         e_fd_f = em ? m_full[ea] : rom_ref(int'(ea));
         e_fd_h = (em && ea < 9'd256) ? m_half[ea[7:0]] : rom_ref(int'(ea));
         e_lo   = fp & ix[0];
      end
      e_err  = hs & em;
      e_hr_f = (hs && !hw && !em) ? m_full[ha] : 32'h0;
      e_hr_h = (hs && !hw && !em) ? m_half[ha[7:0]] : 32'h0;
      if (hs && hw && !em) begin
         m_full[ha]      = merge(m_full[ha], wd, be);
         m_half[ha[7:0]] = merge(m_half[ha[7:0]], wd, be);
      end
      #1;
      chk("R5 ep_addr", 32'(ep_addr_f), 32'(ep_ref(fn, ix)));
      @(posedge clk);
      #1;
      chk({ft, " fetch full"}, fdata_f, e_fd_f);
      chk({fth, " fetch half"}, fdata_h, e_fd_h);
      chk("R6 ep_word", 32'(epw_f), 32'(half_sel(e_fd_f, e_lo)));
      chk(em ? "R8 host_rdata" : "R7 host_rdata", hrd_f, e_hr_f);
      chk("R7 host_rdata half", hrd_h, e_hr_h);
      chk("R8 host_err", 32'(herr_f), 32'(e_err));
      chk("R8 host_err half", 32'(herr_h), 32'(e_err));
   endtask

   task automatic idle(input logic em);
      step(em, 0, 0, 9'd0, 4'd0, 4'd0, 0, 0, 9'd0, 4'h0, 32'h0);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      void'($urandom(32'd1357));
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      chk("R1 fetch_data", fdata_f, 32'h0);
      chk("R1 ep_word", 32'(epw_f), 32'h0);
      chk("R1 host_rdata", hrd_f, 32'h0);
      chk("R1 host_err", 32'(herr_f), 32'h0);
      rst_n = 1'b1;

      // Fill the RAM through the host port
      for (int a = 0; a < 512; a++)
         step(0, 0, 0, 9'd0, 4'd0, 4'd0, 1, 1, 9'(a), 4'hF, $urandom);

      // R2: ROM fetches at both ends
      step(0, 1, 0, 9'd0,   4'd0, 4'd0, 0, 0, 9'd0, 4'h0, 32'h0);
      step(0, 1, 0, 9'd511, 4'd0, 4'd0, 0, 0, 9'd0, 4'h0, 32'h0);
      // R3 / R4: emulation fetches, half RAM boundary at 255/256
      step(1, 1, 0, 9'd0,   4'd0, 4'd0, 0, 0, 9'd0, 4'h0, 32'h0);
      step(1, 1, 0, 9'd255, 4'd0, 4'd0, 0, 0, 9'd0, 4'h0, 32'h0);
      step(1, 1, 0, 9'd256, 4'd0, 4'd0, 0, 0, 9'd0, 4'h0, 32'h0);
      step(1, 1, 0, 9'd511, 4'd0, 4'd0, 0, 0, 9'd0, 4'h0, 32'h0);
      // R5 / R6: entry points, extremes, even and odd index
      step(1, 1, 1, 9'd0, 4'd0,  4'd0,  0, 0, 9'd0, 4'h0, 32'h0);
      step(1, 1, 1, 9'd0, 4'd15, 4'd15, 0, 0, 9'd0, 4'h0, 32'h0);
      step(0, 1, 1, 9'd0, 4'd7,  4'd4,  0, 0, 9'd0, 4'h0, 32'h0);
      step(0, 1, 1, 9'd0, 4'd7,  4'd5,  0, 0, 9'd0, 4'h0, 32'h0);
      // R10: RAM-sourced result held while host reads move the read path
      step(1, 1, 0, 9'd17, 4'd0, 4'd0, 0, 0, 9'd0, 4'h0, 32'h0);
      step(0, 0, 0, 9'd0,  4'd0, 4'd0, 1, 0, 9'd99, 4'h0, 32'h0);
      step(0, 0, 0, 9'd0,  4'd0, 4'd0, 1, 0, 9'd3,  4'h0, 32'h0);
      // R7: partial byte-lane write then readback
      step(0, 0, 0, 9'd0, 4'd0, 4'd0, 1, 1, 9'd40, 4'b0101, 32'hDEADBEEF);
      step(0, 0, 0, 9'd0, 4'd0, 4'd0, 1, 0, 9'd40, 4'h0, 32'h0);
      // R8: blocked write and read during emulation, then check unchanged
      step(1, 0, 0, 9'd0, 4'd0, 4'd0, 1, 1, 9'd40, 4'hF, 32'h12345678);
      step(1, 0, 0, 9'd0, 4'd0, 4'd0, 1, 0, 9'd40, 4'h0, 32'h0);
      idle(1);
      step(0, 0, 0, 9'd0, 4'd0, 4'd0, 1, 0, 9'd40, 4'h0, 32'h0);
      // R9: emulation bit toggling under back-to-back fetches
      force_tag = "R9";
      for (int k = 0; k < 8; k++)
         step(k[0], 1, 0, 9'(k * 37), 4'd0, 4'd0, 0, 0, 9'd0, 4'h0, 32'h0);
      force_tag = "";

      // Seeded random traffic
      for (int n = 0; n < 600; n++) begin
         logic [31:0] r;
         r = $urandom;
         step(r[0] & r[1], r[2], r[3], 9'($urandom), 4'($urandom), 4'($urandom),
              r[4], r[5], 9'($urandom), 4'($urandom), $urandom);
      end

      idle(0);
      finish_run();
   end

endmodule